// File: doc/BRIEF.md
# Banked Cartridge Memory Controller

This block sits between a CPU's 16-bit address bus and a cartridge's ROM and RAM arrays. It watches CPU writes that fall in the 32 KB ROM window and treats them as control writes. From those writes it keeps a small set of bank registers, and it turns each CPU address into a physical ROM or RAM address. The ROM window has two halves. The lower 16 KB always maps to ROM bank 0. The upper 16 KB maps to a selectable bank. A separate 8 KB window maps to a selectable external RAM bank, and that window can be switched on or off.

A shared 2-bit field has two uses, picked by a mode bit. In mode 0 it extends the ROM bank number. In mode 1 it selects the RAM bank. A ROM bank number whose low five bits are zero is bumped to one. Any bank that lies past the end of the configured ROM is wrapped by masking it with the bank count. The ROM and RAM arrays are outside the block. Address translation is combinational from the registered bank state.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with cpu_addr in 0x0000–0x1FFF and data 0x0A turns external RAM on. Data 0x00 turns it off. Any other data leaves the on/off state as it was.
- R2: A write in 0x2000–0x3FFF sets ROM bank bits 4:0 from data[4:0], with the value 0 replaced by 1. ROM bank bits 6:5 keep their current value.
- R3: In mode 0, a write in 0x4000–0x5FFF copies data[1:0] into ROM bank bits 6:5 and keeps bits 4:0.
- R4: In mode 1, a write in 0x4000–0x5FFF copies data[1:0] into the RAM bank and leaves the ROM bank unchanged.
- R5: A write in 0x6000–0x7FFF sets the mode to data[0]. Writing 1 clears ROM bank bits 6:5. Writing 0 sets the RAM bank to 0.
- R6: rom_size_sel = n means a ROM of 32 KB << n, with n from 0 to 6 (values above 6 act as 6). The bank that is stored and used is the requested bank ANDed with ((2 << n) − 1).
- R7: If cpu_addr[14] = 0, rom_addr = cpu_addr[13:0] (bank 0). If cpu_addr[14] = 1, rom_addr = bank × 0x4000 + cpu_addr[13:0].
- R8: ram_addr = RAM bank × 0x2000 + cpu_addr[12:0]. ram_sel is 1 only when cpu_addr is in 0xA000–0xBFFF and external RAM is on.
- R9: ext_rdata equals ram_rdata when ram_sel is 1, and 0xFF otherwise. In particular it reads 0xFF in the RAM window while RAM is off.
- R10: ram_we is 1 only when cpu_we is 1, cpu_addr is in 0xA000–0xBFFF and external RAM is on.
- R11: After reset the ROM bank is 1, the RAM bank is 0, external RAM is off and the mode is 0.
- R12: Writes with cpu_addr at 0x8000 or above leave the ROM bank, the RAM bank, the mode and the RAM on/off state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| rom_size_sel | input | 3 | ROM size code n, meaning 32 KB << n |
| ram_rdata | input | 8 | Read data from the external RAM array |
| rom_addr | output | 21 | Physical ROM byte address |
| ram_addr | output | 15 | Physical external RAM byte address |
| ram_sel | output | 1 | External RAM window is addressed and RAM is on |
| ram_we | output | 1 | Write strobe to the external RAM array |
| ext_rdata | output | 8 | External RAM read data as seen by the CPU |

## Verification
The bank registers are swept over every low-bank value, every 2-bit upper value and every ROM size code. Each combination is checked at both edges of the switchable window. This covers the zero-to-one remap, the carry of the upper bits, and wrapping at each size. Mode changes are tried in both directions with non-zero upper bits. This shows the clearing of bits 6:5 and the reset of the RAM bank, and it shows that the 0x4000 field reaches only the RAM bank in mode 1. The on/off register is tested with 0x0A, 0x00 and other values. Its effect is observed through ram_sel, ram_we and the 0xFF read value. Writes above 0x8000 are checked to leave all state unchanged.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int CPU_AW     = 16;
  localparam int CPU_DW     = 8;
  localparam int ROM_BANK_W = 7;
  localparam int RAM_BANK_W = 2;
  localparam int ROM_OFS_W  = 14;
  localparam int RAM_OFS_W  = 13;
  localparam int SIZE_SEL_W = 3;
  localparam int SIZE_SEL_MAX = 6;

  // Control window selected by cpu_addr[14:13] inside the ROM range.
  typedef enum logic [1:0] {
    WIN_RAM_EN  = 2'd0,
    WIN_BANK_LO = 2'd1,
    WIN_SHARED  = 2'd2,
    WIN_MODE    = 2'd3
  } ctl_win_e;

  localparam logic [CPU_DW-1:0] RAM_ON_CODE  = 8'h0A;
  localparam logic [CPU_DW-1:0] RAM_OFF_CODE = 8'h00;
  localparam logic [CPU_DW-1:0] OPEN_BUS     = 8'hFF;
endpackage

// File: rtl/cart_bank_wrap.sv
module cart_bank_wrap #(
  parameter int BANK_W = 7,
  parameter int SEL_W  = 3,
  parameter int SEL_MAX = 6
) (
  input  logic [BANK_W-1:0] bank_in,
  input  logic [SEL_W-1:0]  size_sel,
  output logic [BANK_W-1:0] bank_out
);
  logic [SEL_W-1:0]  sel_c;
  logic [BANK_W-1:0] mask;

  always_comb begin
    if (int'(size_sel) > SEL_MAX) sel_c = SEL_W'(SEL_MAX);
    else                          sel_c = size_sel;
  end

  // Bank count is 2 << sel, so the mask has bits 0..sel set.
  for (genvar i = 0; i < BANK_W; i++) begin : g_mask
    assign mask[i] = (int'(sel_c) >= i);
  end

  assign bank_out = bank_in & mask;
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int ROM_BW = ROM_BANK_W,
  parameter int RAM_BW = RAM_BANK_W,
  parameter int DW     = CPU_DW,
  parameter int SEL_W  = SIZE_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        addr_top,
  input  logic [DW-1:0]     wdata,
  input  logic [SEL_W-1:0]  size_sel,
  output logic [ROM_BW-1:0] rom_bank_q,
  output logic [RAM_BW-1:0] ram_bank_q,
  output logic              mode_q,
  output logic              ram_en_q
);
  localparam int LO_W = ROM_BW - RAM_BW;

  ctl_win_e          win;
  logic              ctl_wr;
  logic [LO_W-1:0]   lo_req;
  logic [ROM_BW-1:0] cand;
  logic [ROM_BW-1:0] bank_next;

  assign win    = ctl_win_e'(addr_top[1:0]);
  assign ctl_wr = we && !addr_top[2];
  assign lo_req = (wdata[LO_W-1:0] == '0) ? LO_W'(1) : wdata[LO_W-1:0];

  always_comb begin
    cand = rom_bank_q;
    unique case (win)
      WIN_BANK_LO: cand = {rom_bank_q[ROM_BW-1:LO_W], lo_req};
      WIN_SHARED:  if (!mode_q) cand = {wdata[RAM_BW-1:0], rom_bank_q[LO_W-1:0]};
      WIN_MODE:    if (wdata[0]) cand = {{RAM_BW{1'b0}}, rom_bank_q[LO_W-1:0]};
      default:     cand = rom_bank_q;
    endcase
  end

  cart_bank_wrap #(
    .BANK_W (ROM_BW),
    .SEL_W  (SEL_W),
    .SEL_MAX(SIZE_SEL_MAX)
  ) u_wrap (
    .bank_in (cand),
    .size_sel(size_sel),
    .bank_out(bank_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_bank_q <= ROM_BW'(1);
      ram_bank_q <= '0;
      mode_q     <= 1'b0;
      ram_en_q   <= 1'b0;
    end else if (ctl_wr) begin
      unique case (win)
        WIN_RAM_EN: begin
          if (wdata == RAM_ON_CODE)       ram_en_q <= 1'b1;
          else if (wdata == RAM_OFF_CODE) ram_en_q <= 1'b0;
        end
        WIN_BANK_LO: rom_bank_q <= bank_next;
        WIN_SHARED: begin
          if (mode_q) ram_bank_q <= wdata[RAM_BW-1:0];
          else        rom_bank_q <= bank_next;
        end
        WIN_MODE: begin
          mode_q <= wdata[0];
          if (wdata[0]) rom_bank_q <= bank_next;
          else          ram_bank_q <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
  import cart_bank_pkg::*;
#(
  parameter int AW     = CPU_AW,
  parameter int DW     = CPU_DW,
  parameter int ROM_BW = ROM_BANK_W,
  parameter int RAM_BW = RAM_BANK_W,
  parameter int ROM_OW = ROM_OFS_W,
  parameter int RAM_OW = RAM_OFS_W,
  parameter int SEL_W  = SIZE_SEL_W
) (
  input  logic [AW-1:0]            addr,
  input  logic                     we,
  input  logic [SEL_W-1:0]         size_sel,
  input  logic [ROM_BW-1:0]        rom_bank_q,
  input  logic [RAM_BW-1:0]        ram_bank_q,
  input  logic                     ram_en_q,
  input  logic [DW-1:0]            ram_rdata,
  output logic [ROM_BW+ROM_OW-1:0] rom_addr,
  output logic [RAM_BW+RAM_OW-1:0] ram_addr,
  output logic                     ram_sel,
  output logic                     ram_we,
  output logic [DW-1:0]            ext_rdata
);
  localparam logic [2:0] RAM_WIN_TAG = 3'b101;

  logic [ROM_BW-1:0] bank_eff;
  logic              in_ram_win;

  // Re-applying the size mask keeps the output valid if the size code moves.
  cart_bank_wrap #(
    .BANK_W (ROM_BW),
    .SEL_W  (SEL_W),
    .SEL_MAX(SIZE_SEL_MAX)
  ) u_wrap (
    .bank_in (rom_bank_q),
    .size_sel(size_sel),
    .bank_out(bank_eff)
  );

  assign in_ram_win = (addr[AW-1:AW-3] == RAM_WIN_TAG);

  always_comb begin
    if (addr[ROM_OW]) rom_addr = {bank_eff, addr[ROM_OW-1:0]};
    else              rom_addr = {{ROM_BW{1'b0}}, addr[ROM_OW-1:0]};
  end

  assign ram_addr  = {ram_bank_q, addr[RAM_OW-1:0]};
  assign ram_sel   = in_ram_win && ram_en_q;
  assign ram_we    = ram_sel && we;
  assign ext_rdata = ram_sel ? ram_rdata : OPEN_BUS;
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int AW     = CPU_AW,
  parameter int DW     = CPU_DW,
  parameter int ROM_BW = ROM_BANK_W,
  parameter int RAM_BW = RAM_BANK_W,
  parameter int ROM_OW = ROM_OFS_W,
  parameter int RAM_OW = RAM_OFS_W,
  parameter int SEL_W  = SIZE_SEL_W,
  localparam int ROM_AW = ROM_BW + ROM_OW,
  localparam int RAM_AW = RAM_BW + RAM_OW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_we,
  input  logic [SEL_W-1:0]  rom_size_sel,
  input  logic [DW-1:0]     ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [DW-1:0]     ext_rdata
);
  logic [ROM_BW-1:0] rom_bank_q;
  logic [RAM_BW-1:0] ram_bank_q;
  logic              mode_q;
  logic              ram_en_q;

  cart_bank_regs #(
    .ROM_BW(ROM_BW), .RAM_BW(RAM_BW), .DW(DW), .SEL_W(SEL_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (cpu_we),
    .addr_top  (cpu_addr[AW-1:AW-3]),
    .wdata     (cpu_wdata),
    .size_sel  (rom_size_sel),
    .rom_bank_q(rom_bank_q),
    .ram_bank_q(ram_bank_q),
    .mode_q    (mode_q),
    .ram_en_q  (ram_en_q)
  );

  cart_bank_xlate #(
    .AW(AW), .DW(DW), .ROM_BW(ROM_BW), .RAM_BW(RAM_BW),
    .ROM_OW(ROM_OW), .RAM_OW(RAM_OW), .SEL_W(SEL_W)
  ) u_xlate (
    .addr      (cpu_addr),
    .we        (cpu_we),
    .size_sel  (rom_size_sel),
    .rom_bank_q(rom_bank_q),
    .ram_bank_q(ram_bank_q),
    .ram_en_q  (ram_en_q),
    .ram_rdata (ram_rdata),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .ram_sel   (ram_sel),
    .ram_we    (ram_we),
    .ext_rdata (ext_rdata)
  );
endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_we,
  input logic [2:0]  rom_size_sel,
  input logic [20:0] rom_addr,
  input logic        ram_we,
  input logic [7:0]  ext_rdata,
  input logic [6:0]  rom_bank_q,
  input logic [1:0]  ram_bank_q,
  input logic        ram_en_q
);
  logic [6:0] size_mask;
  always_comb begin
    for (int i = 0; i < 7; i++)
      size_mask[i] = (int'(rom_size_sel) >= i) || (i == 0);
  end

  // R1: the enable code turns RAM on
  p_en_set_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr[15:13] == 3'b000 && cpu_wdata == 8'h0A) |=> ram_en_q);

  // R1: other codes leave the enable as it was
  p_en_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr[15:13] == 3'b000 && cpu_wdata != 8'h0A && cpu_wdata != 8'h00)
      |=> $stable(ram_en_q));

  // R2: a low-bank write never leaves bits 4:0 at zero when the ROM has 32 or more banks
  p_lo_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr[15:13] == 3'b001 && rom_size_sel >= 3'd4 && $stable(rom_size_sel))
      |=> (rom_bank_q[4:0] != 5'd0));

  // R5: leaving mode 1 clears the RAM bank
  p_ram_bank_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && cpu_addr[15:13] == 3'b011 && !cpu_wdata[0]) |=> (ram_bank_q == 2'd0));

  // R6: the upper window never points past the configured ROM
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr[15:14] == 2'b01) |-> ((rom_addr[20:14] & ~size_mask) == 7'd0));

  // R9: open-bus value while RAM is off
  p_ff_off_r9: assert property (@(posedge clk) disable iff (rst)
    !ram_en_q |-> (ext_rdata == 8'hFF));

  // R10: no RAM write strobe unless RAM is on and written
  p_we_gate_r10: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_en_q && cpu_we));

  // R11: state right after reset release
  p_reset_r11: assert property (@(posedge clk)
    $fell(rst) |-> (rom_bank_q == 7'd1 && ram_bank_q == 2'd0 && !ram_en_q));
endmodule

bind cart_bank_ctrl cart_bank_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cpu_addr    (cpu_addr),
  .cpu_wdata   (cpu_wdata),
  .cpu_we      (cpu_we),
  .rom_size_sel(rom_size_sel),
  .rom_addr    (rom_addr),
  .ram_we      (ram_we),
  .ext_rdata   (ext_rdata),
  .rom_bank_q  (rom_bank_q),
  .ram_bank_q  (ram_bank_q),
  .ram_en_q    (ram_en_q)
);

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic [2:0]  rom_size_sel = 3'd6;
  logic [7:0]  ram_rdata = 8'h5C;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_sel;
  logic        ram_we;
  logic [7:0]  ext_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  cart_bank_ctrl dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .rom_size_sel(rom_size_sel), .ram_rdata(ram_rdata),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_sel(ram_sel),
    .ram_we(ram_we), .ext_rdata(ext_rdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic look(input logic [15:0] a);
    cpu_addr = a;
    #1;
  endtask

  function automatic logic [31:0] exp_rom(input int bank, input int sel, input int ofs);
    int s = (sel > 6) ? 6 : sel;
    return 32'(((bank & ((2 << s) - 1)) << 14) | ofs);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state seen at the ports
    look(16'h4000); chk("R11 rom bank 1", rom_addr, 32'h4000);
    look(16'hA000); chk("R11 ram off", ram_sel, 0);
    chk("R11 ram bank 0", ram_addr, 32'h0000);
    // R7: fixed window
    look(16'h1234); chk("R7 fixed window", rom_addr, 32'h1234);
    look(16'h3FFF); chk("R7 fixed window top", rom_addr, 32'h3FFF);

    // R2 R3 R6 R7: sweep all sizes, low values and upper values
    for (int s = 0; s < 8; s++) begin
      rom_size_sel = 3'(s);
      for (int lo = 0; lo < 32; lo++) begin
        for (int hi = 0; hi < 4; hi++) begin
          int req;
          wr(16'h2000 | 16'(lo), 8'(lo) | 8'hE0);
          wr(16'h5FFF, 8'(hi) | 8'hFC);
          req = (hi << 5) | ((lo == 0) ? 1 : lo);
          look(16'h4000); chk("R2 R3 R6 R7 bank low edge", rom_addr, exp_rom(req, s, 0));
          look(16'h7FFF); chk("R2 R3 R6 R7 bank high edge", rom_addr, exp_rom(req, s, 16'h3FFF));
        end
      end
    end

    rom_size_sel = 3'd6;
    // R5: entering mode 1 clears bits 6:5
    wr(16'h2100, 8'h05); wr(16'h4000, 8'h03);
    look(16'h4000); chk("R3 upper bits set", rom_addr, exp_rom(8'h65, 6, 0));
    wr(16'h6000, 8'h01);
    look(16'h4000); chk("R5 mode1 clears upper bits", rom_addr, exp_rom(5, 6, 0));
    // R4: mode 1 shared field goes to the RAM bank only
    wr(16'h0000, 8'h0A);
    for (int k = 0; k < 4; k++) begin
      wr(16'h4000, 8'(k));
      look(16'hA123); chk("R4 ram bank", ram_addr, 32'(k * 16'h2000 + 16'h0123));
      look(16'h4000); chk("R4 rom bank unchanged", rom_addr, exp_rom(5, 6, 0));
    end
    // R8: upper edge of RAM window
    look(16'hBFFF); chk("R8 ram addr top", ram_addr, 32'h7FFF);
    chk("R8 ram_sel on", ram_sel, 1);
    // R5: back to mode 0 zeroes RAM bank
    wr(16'h7000, 8'h00);
    look(16'hA010); chk("R5 mode0 ram bank 0", ram_addr, 32'h0010);
    wr(16'h4000, 8'h02);
    look(16'hA010); chk("R3 mode0 ram bank stays", ram_addr, 32'h0010);
    look(16'h4000); chk("R3 mode0 upper bits", rom_addr, exp_rom(8'h45, 6, 0));

    // R1 R9 R10: enable behaviour
    look(16'hA000); chk("R9 data when on", ext_rdata, 32'h5C);
    wr(16'h1FFF, 8'h55);
    look(16'hA000); chk("R1 other code holds on", ram_sel, 1);
    wr(16'h0000, 8'h00);
    look(16'hA000); chk("R1 off", ram_sel, 0);
    chk("R9 open bus", ext_rdata, 32'hFF);
    wr(16'h0000, 8'h0B);
    look(16'hA000); chk("R1 other code holds off", ram_sel, 0);
    look(16'h9000); chk("R8 ram_sel outside window", ram_sel, 0);
    @(negedge clk); cpu_addr = 16'hA000; cpu_we = 1'b1; #1;
    chk("R10 no strobe when off", ram_we, 0);
    @(negedge clk); cpu_we = 1'b0;
    wr(16'h0000, 8'h0A);
    @(negedge clk); cpu_addr = 16'hA000; cpu_we = 1'b1; #1;
    chk("R10 strobe when on", ram_we, 1);
    @(negedge clk); cpu_we = 1'b0; #1;
    chk("R10 no strobe on read", ram_we, 0);
    look(16'hC000); chk("R8 ram_sel above window", ram_sel, 0);

    // R12: writes at 0x8000 and above change nothing
    wr(16'h6000, 8'h01); wr(16'h4000, 8'h01);
    wr(16'h8000, 8'h00); wr(16'hA000, 8'h00); wr(16'hFFFF, 8'h00); wr(16'hC000, 8'h01);
    look(16'h4000); chk("R12 rom bank kept", rom_addr, exp_rom(5, 6, 0));
    look(16'hA001); chk("R12 ram on kept", ram_sel, 1);
    chk("R12 ram bank kept", ram_addr, 32'h2001);
    wr(16'h4000, 8'h03);
    look(16'hA001); chk("R12 mode kept", ram_addr, 32'h6001);

    // R11: reset again from a busy state
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    look(16'h4000); chk("R11 rom bank after reset", rom_addr, 32'h4000);
    look(16'hA000); chk("R11 ram off after reset", ram_sel, 0);
    wr(16'h0000, 8'h0A); wr(16'h4000, 8'h02);
    look(16'hA000); chk("R11 mode 0 after reset", ram_addr, 32'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule